// File: doc/BRIEF.md
# Serial EEPROM Byte Access Port

This block connects a 32-bit register interface to an external two-wire serial EEPROM. It performs one single-byte read or write per request. The host uses two registers, selected by `reg_sel`. The control word holds the byte address, the access direction, a start bit, two initialization flags and an error flag. The data word carries the byte to be written or the byte that was read.

When reset is released, the block reads EEPROM locations 0 and 1 without any host action and compares them with two signature constants. It then reports that initialization has finished and whether the signature matched.

Every attempt that is not acknowledged ends with a STOP and is retried. Once the retry limit is used up, the error flag is raised. The serial clock comes from the system clock through a programmable divider. Both bus lines are open-drain: the block only ever pulls them low or lets them go.

Top module: `serial_nvm_port`

## Requirements
- R1: Control bit 28 is an error flag. It sets when one request collects MAX_TRY (default 3) unacknowledged attempts. Writing a 1 to bit 28 clears it, and writing a 0 there leaves it unchanged.
- R2: Control bit 27 is read-only. It sets once the power-up signature load has finished, whether the load passed or failed. Host writes never change it.
- R3: The power-up load starts by itself on reset release. It reads byte 0 and then byte 1 from device address 0x50.
- R4: Control bit 26 is read-only. It sets only when byte 0 equals 0xA5 and byte 1 equals 0x3C.
- R5: Writing control bit 25 as 1 while the block is idle starts a request. Bit 25 reads 1 while that request runs and clears when it ends, on success or on error.
- R6: Control bit 24 sets the direction. A value of 1 reads the addressed byte into the data register. A value of 0 writes data register bits 7:0 to the addressed byte.
- R7: Control bits 7:0 hold the byte address. Control bits 31:29 and 23:8 read as zero, and the control word reads zero during reset.
- R8: The data register is selected with `reg_sel`=1. It uses bits 7:0, and bits 31:8 read as zero.
- R9: A missing acknowledge on any address or data byte ends the attempt with a STOP and starts a new attempt. A request that succeeds on a later attempt leaves the error flag clear.
- R10: The bus is open-drain. Both lines are released whenever no request or load is running. A transfer uses START, a repeated START before a read, and a STOP.
- R11: While a request or the power-up load is running, host writes to the control fields and to the data register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 for control, 1 for data |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| sda_in | input | 1 | Sensed level of the serial data line |
| scl_drive_low | output | 1 | Pulls the serial clock line low when 1 |
| sda_drive_low | output | 1 | Pulls the serial data line low when 1 |

## Verification
The bound checker watches several rules on every cycle:
- the start bit is set only while the engine is busy;
- the finished flag never drops, and the valid flag never appears without it;
- the error flag rises only when the engine returns to idle;
- both lines are free whenever the engine is idle;
- the reserved bits of either register read as zero.

Other behaviours depend on what the bus partner answers, so only the bench scenarios can show them:
- whether the signature comparison passes or fails;
- how many attempts a request takes before it succeeds or gives up;
- which byte actually lands in the EEPROM;
- that writes issued during a busy period leave no trace.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

   typedef enum logic [1:0] {SYM_START, SYM_STOP, SYM_BIT} sym_t;

   typedef enum logic [1:0] {K_START, K_WBYTE, K_RBYTE, K_STOP} kind_t;

   typedef enum logic [1:0] {OP_SIG0, OP_SIG1, OP_HOST} op_t;

   typedef enum logic [1:0] {ST_IDLE, ST_LAUNCH, ST_WAIT} st_t;

   localparam int CTL_ERR    = 28;
   localparam int CTL_IDONE  = 27;
   localparam int CTL_IVALID = 26;
   localparam int CTL_GO     = 25;
   localparam int CTL_RD     = 24;

endpackage

// File: rtl/nvm_tick.sv
module nvm_tick #(
   parameter int QDIV = 8
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   generate
      if (QDIV == 1) begin : g_pass
         logic unused_in;
         assign unused_in = clk ^ rst_n;
         assign tick = 1'b1;
      end else begin : g_cnt
         localparam int CW = $clog2(QDIV);
         localparam logic [CW-1:0] LAST = CW'(QDIV - 1);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           cnt <= '0;
            else if (cnt == LAST) cnt <= '0;
            else                  cnt <= cnt + 1'b1;
         end
         assign tick = (cnt == LAST);
      end
   endgenerate
endmodule

// File: rtl/nvm_bitphy.sv
module nvm_bitphy
   import nvm_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic go,
   input  sym_t sym,
   input  logic tx,
   input  logic sda_in,
   output logic done,
   output logic rx,
   output logic scl_low,
   output logic sda_low
);
   logic       busy;
   logic [1:0] q;
   sym_t       sym_q;
   logic       tx_q;
   logic       nx_scl, nx_sda;

   // each symbol is four quarter periods; SCL high in quarters 1 and 2
   always_comb begin
      case (sym_q)
         SYM_START: begin nx_scl = (q == 2'd0) || (q == 2'd3); nx_sda = q[1];  end
         SYM_STOP:  begin nx_scl = (q == 2'd0);                nx_sda = !q[1]; end
         default:   begin nx_scl = (q == 2'd0) || (q == 2'd3); nx_sda = !tx_q; end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         q       <= 2'd0;
         sym_q   <= SYM_STOP;
         tx_q    <= 1'b1;
         done    <= 1'b0;
         rx      <= 1'b1;
         scl_low <= 1'b0;
         sda_low <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (go) begin
               busy  <= 1'b1;
               q     <= 2'd0;
               sym_q <= sym;
               tx_q  <= tx;
            end
         end else if (tick) begin
            scl_low <= nx_scl;
            sda_low <= nx_sda;
            if (sym_q == SYM_BIT && q == 2'd2) rx <= sda_in;
            q <= q + 2'd1;
            if (q == 2'd3) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/nvm_xfer.sv
module nvm_xfer
   import nvm_pkg::*;
#(
   parameter logic [6:0] DEV = 7'h50
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go,
   input  logic       rd,
   input  logic [7:0] addr,
   input  logic [7:0] wdata,
   input  logic       phy_done,
   input  logic       phy_rx,
   output logic       phy_go,
   output sym_t       phy_sym,
   output logic       phy_tx,
   output logic       done,
   output logic       nak,
   output logic [7:0] rdata
);
   logic       active, inflight, rd_q, nak_q;
   logic [2:0] step, last_step;
   logic [3:0] bitn;
   logic [7:0] addr_q, wdata_q, shreg, wval;
   kind_t      kind;

   always_comb begin
      last_step = rd_q ? 3'd6 : 3'd4;
      case (step)
         3'd0:       kind = K_START;
         3'd1, 3'd2: kind = K_WBYTE;
         3'd3:       kind = rd_q ? K_START : K_WBYTE;
         3'd4:       kind = rd_q ? K_WBYTE : K_STOP;
         3'd5:       kind = K_RBYTE;
         default:    kind = K_STOP;
      endcase
      case (step)
         3'd1:    wval = {DEV, 1'b0};
         3'd2:    wval = addr_q;
         3'd3:    wval = wdata_q;
         default: wval = {DEV, 1'b1};
      endcase
      phy_go = active && !inflight;
      case (kind)
         K_START: phy_sym = SYM_START;
         K_STOP:  phy_sym = SYM_STOP;
         default: phy_sym = SYM_BIT;
      endcase
      phy_tx = (kind == K_WBYTE && !bitn[3]) ? wval[~bitn[2:0]] : 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0; inflight <= 1'b0; rd_q <= 1'b0; nak_q <= 1'b0;
         step <= 3'd0; bitn <= 4'd0; addr_q <= '0; wdata_q <= '0;
         shreg <= '0; done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!active) begin
            if (go) begin
               active <= 1'b1; inflight <= 1'b0; step <= 3'd0; bitn <= 4'd0;
               nak_q <= 1'b0; rd_q <= rd; addr_q <= addr; wdata_q <= wdata;
            end
         end else if (phy_go) begin
            inflight <= 1'b1;
         end else if (phy_done) begin
            inflight <= 1'b0;
            case (kind)
               K_START: step <= step + 3'd1;
               K_STOP: begin
                  active <= 1'b0;
                  done   <= 1'b1;
               end
               K_WBYTE: begin
                  if (bitn[3]) begin
                     bitn <= 4'd0;
                     if (phy_rx) begin
                        nak_q <= 1'b1;
                        step  <= last_step;
                     end else begin
                        step <= step + 3'd1;
                     end
                  end else begin
                     bitn <= bitn + 4'd1;
                  end
               end
               default: begin
                  if (!bitn[3]) shreg <= {shreg[6:0], phy_rx};
                  if (bitn[3]) begin
                     bitn <= 4'd0;
                     step <= step + 3'd1;
                  end else begin
                     bitn <= bitn + 4'd1;
                  end
               end
            endcase
         end
      end
   end

   assign nak   = nak_q;
   assign rdata = shreg;
endmodule

// File: rtl/serial_nvm_port.sv
module serial_nvm_port
   import nvm_pkg::*;
#(
   parameter int         QDIV     = 16,
   parameter logic [6:0] DEV_ADDR = 7'h50,
   parameter logic [7:0] SIG0     = 8'hA5,
   parameter logic [7:0] SIG1     = 8'h3C,
   parameter int         MAX_TRY  = 3
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_we,
   input  logic        reg_sel,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   input  logic        sda_in,
   output logic        scl_drive_low,
   output logic        sda_drive_low
);
   localparam int TW = $clog2(MAX_TRY + 1);
   localparam logic [TW-1:0] TRY_LAST = TW'(MAX_TRY - 1);

   initial begin : p_param_chk
      if (QDIV < 1)                    $fatal(1, "QDIV must be at least 1");
      if (MAX_TRY < 1 || MAX_TRY > 15) $fatal(1, "MAX_TRY out of range");
   end

   st_t           st;
   op_t           op;
   logic [TW-1:0] tries;
   logic          err_q, idone_q, ivalid_q, start_q, rd_q, sig0_ok;
   logic [7:0]    addr_q, data_q;
   logic          busy, ctl_wr, dat_wr, fail;
   logic          x_go, x_rd, x_done, x_nak;
   logic [7:0]    x_addr, x_rdata;
   logic          tick, p_go, p_tx, p_done, p_rx;
   sym_t          p_sym;
   logic          unused_wr;

   assign unused_wr = ^{reg_wdata[31:29], reg_wdata[27:26], reg_wdata[23:8]};
   assign busy   = (st != ST_IDLE);
   assign ctl_wr = reg_we && !reg_sel;
   assign dat_wr = reg_we && reg_sel;
   assign x_go   = (st == ST_LAUNCH);
   assign x_rd   = (op != OP_HOST) || rd_q;
   assign x_addr = (op == OP_SIG0) ? 8'h00 : (op == OP_SIG1) ? 8'h01 : addr_q;
   assign fail   = (st == ST_WAIT) && x_done && x_nak && (tries == TRY_LAST);

   assign reg_rdata = reg_sel ? {24'h0, data_q}
                              : {3'b000, err_q, idone_q, ivalid_q, start_q, rd_q, 16'h0, addr_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_LAUNCH; op <= OP_SIG0; tries <= '0;
         err_q <= 1'b0; idone_q <= 1'b0; ivalid_q <= 1'b0; start_q <= 1'b0;
         rd_q <= 1'b0; sig0_ok <= 1'b0; addr_q <= '0; data_q <= '0;
      end else begin
         if (ctl_wr && reg_wdata[CTL_ERR]) err_q <= 1'b0;
         if (fail)                         err_q <= 1'b1;
         case (st)
            ST_IDLE: begin
               if (ctl_wr) begin
                  rd_q   <= reg_wdata[CTL_RD];
                  addr_q <= reg_wdata[7:0];
                  if (reg_wdata[CTL_GO]) begin
                     start_q <= 1'b1;
                     op      <= OP_HOST;
                     tries   <= '0;
                     st      <= ST_LAUNCH;
                  end
               end
               if (dat_wr) data_q <= reg_wdata[7:0];
            end
            ST_LAUNCH: st <= ST_WAIT;
            default: begin
               if (x_done) begin
                  if (x_nak) begin
                     if (fail) begin
                        st      <= ST_IDLE;
                        start_q <= 1'b0;
                        if (op != OP_HOST) begin
                           idone_q  <= 1'b1;
                           ivalid_q <= 1'b0;
                        end
                     end else begin
                        tries <= tries + 1'b1;
                        st    <= ST_LAUNCH;
                     end
                  end else begin
                     tries <= '0;
                     case (op)
                        OP_SIG0: begin
                           sig0_ok <= (x_rdata == SIG0);
                           op      <= OP_SIG1;
                           st      <= ST_LAUNCH;
                        end
                        OP_SIG1: begin
                           idone_q  <= 1'b1;
                           ivalid_q <= sig0_ok && (x_rdata == SIG1);
                           st       <= ST_IDLE;
                        end
                        default: begin
                           start_q <= 1'b0;
                           if (rd_q) data_q <= x_rdata;
                           st <= ST_IDLE;
                        end
                     endcase
                  end
               end
            end
         endcase
      end
   end

   nvm_tick #(.QDIV(QDIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

   nvm_xfer #(.DEV(DEV_ADDR)) u_xfer (
      .clk(clk), .rst_n(rst_n), .go(x_go), .rd(x_rd), .addr(x_addr),
      .wdata(data_q), .phy_done(p_done), .phy_rx(p_rx), .phy_go(p_go),
      .phy_sym(p_sym), .phy_tx(p_tx), .done(x_done), .nak(x_nak), .rdata(x_rdata)
   );

   nvm_bitphy u_phy (
      .clk(clk), .rst_n(rst_n), .tick(tick), .go(p_go), .sym(p_sym), .tx(p_tx),
      .sda_in(sda_in), .done(p_done), .rx(p_rx),
      .scl_low(scl_drive_low), .sda_low(sda_drive_low)
   );
endmodule

// File: rtl/nvm_port_chk.sv
module nvm_port_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        busy,
   input logic        start_q,
   input logic        idone_q,
   input logic        ivalid_q,
   input logic        err_q,
   input logic        scl_low,
   input logic        sda_low,
   input logic        reg_sel,
   input logic [31:0] reg_rdata
);
   AST_GO_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |-> busy);                                        // R5
   AST_IDONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      idone_q |=> idone_q);                                     // R2
   AST_VALID_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      ivalid_q |-> idone_q);                                    // R4
   AST_ERR_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_q) |-> !busy);                                  // R1
   AST_LINES_FREE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!scl_low && !sda_low));                        // R10
   AST_CTL_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_sel |-> (reg_rdata[23:8] == 16'h0 && reg_rdata[31:29] == 3'b000)); // R7
   AST_DATA_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      reg_sel |-> (reg_rdata[31:8] == 24'h0));                  // R8
endmodule

bind serial_nvm_port nvm_port_chk u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .start_q(start_q), .idone_q(idone_q),
   .ivalid_q(ivalid_q), .err_q(err_q), .scl_low(scl_drive_low),
   .sda_low(sda_drive_low), .reg_sel(reg_sel), .reg_rdata(reg_rdata)
);

// File: tb/sim_serial_nvm_port.sv
`timescale 1ns/1ps
module sim_serial_nvm_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic        reg_sel = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        scl_drive_low, sda_drive_low;
   logic        slv_low;
   logic        sda_line, scl_line;

   int total = 0;
   int bad = 0;

   // bus partner state
   logic [7:0] mem [256];
   logic       present = 1'b1;
   int         nak_left = 0;
   int         nak_cnt = 0;
   int         rd_log [$];
   int         ph, rc;
   logic [7:0] sh, ptr;
   logic       mack, scl_p, sda_p;

   localparam int PH_IDLE = 0, PH_DEV = 1, PH_ADDR = 2, PH_WR = 3, PH_RD = 4;

   always #4 clk = ~clk;

   assign scl_line = !scl_drive_low;
   assign sda_line = !(sda_drive_low || slv_low);

   serial_nvm_port #(.QDIV(2)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sda_in(sda_line),
      .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low)
   );

   // behavioural EEPROM on the two lines
   always @(posedge clk) begin
      if (!rst_n) begin
         ph = PH_IDLE; rc = 0; scl_p = 1'b1; sda_p = 1'b1; mack = 1'b1;
         slv_low <= 1'b0;
      end else begin
         if (scl_line && scl_p && sda_p && !sda_line) begin
            rc = 0; ph = PH_DEV; slv_low <= 1'b0;
         end else if (scl_line && scl_p && !sda_p && sda_line) begin
            ph = PH_IDLE; slv_low <= 1'b0;
         end else if (scl_line && !scl_p) begin
            rc = rc + 1;
            if (rc <= 8) sh = {sh[6:0], sda_line};
            if (rc == 9) mack = sda_line;
         end else if (!scl_line && scl_p) begin
            if (rc == 8) begin
               case (ph)
                  PH_DEV: begin
                     if (present && sh[7:1] == 7'h50 && nak_left == 0) begin
                        slv_low <= 1'b1;
                        if (sh[0]) begin ph = PH_RD; rd_log.push_back(int'(ptr)); end
                        else ph = PH_ADDR;
                     end else begin
                        if (present && nak_left > 0) nak_left = nak_left - 1;
                        nak_cnt = nak_cnt + 1;
                        ph = PH_IDLE;
                     end
                  end
                  PH_ADDR: begin ptr = sh; slv_low <= 1'b1; ph = PH_WR; end
                  PH_WR:   begin mem[ptr] = sh; ptr = ptr + 8'd1; slv_low <= 1'b1; end
                  PH_RD:   begin slv_low <= 1'b0; ptr = ptr + 8'd1; end
                  default: slv_low <= 1'b0;
               endcase
            end else if (rc == 9) begin
               rc = 0;
               if (ph == PH_RD && !mack) slv_low <= !mem[ptr][7];
               else begin
                  slv_low <= 1'b0;
                  if (ph == PH_RD) ph = PH_IDLE;
               end
            end else if (ph == PH_RD && rc >= 1 && rc <= 7) begin
               slv_low <= !mem[ptr][7 - rc];
            end
         end
         scl_p = scl_line;
         sda_p = sda_line;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic sel, input logic [31:0] v);
      @(negedge clk);
      reg_we = 1'b1; reg_sel = sel; reg_wdata = v;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic sel, output logic [31:0] v);
      reg_sel = sel;
      #1;
      v = reg_rdata;
   endtask

   task automatic wait_idle(input string req);
      logic [31:0] v;
      int n = 0;
      rd(1'b0, v);
      while (!(v[27] && !v[25]) && n < 20000) begin
         @(negedge clk);
         rd(1'b0, v);
         n++;
      end
      check({req, " finish in time"}, 32'(n < 20000), 32'd1);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin : p_watchdog
      #(8 * 150000);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : p_main
      logic [31:0] v;
      int n0;
      for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
      mem[0] = 8'hA5;
      mem[1] = 8'h3C;

      repeat (2) @(negedge clk);
      rd(1'b0, v); check("R7 control reset value", v, 32'h0);
      rd(1'b1, v); check("R8 data reset value", v, 32'h0);
      check("R10 lines free in reset", {30'h0, scl_drive_low, sda_drive_low}, 32'h0);
      rst_n = 1'b1;

      wait_idle("R3");
      rd(1'b0, v); check("R2 R4 signature pass flags", v, 32'h0C00_0000);
      check("R3 two load reads", rd_log.size(), 2);
      if (rd_log.size() == 2) begin
         check("R3 first load address", rd_log[0], 0);
         check("R3 second load address", rd_log[1], 1);
      end
      check("R10 lines free after load", {30'h0, scl_drive_low, sda_drive_low}, 32'h0);

      // host write, plus writes that must be ignored while busy
      wr(1'b1, 32'h0000_0077);
      wr(1'b0, 32'h0200_0020);
      rd(1'b0, v); check("R5 start reads one while running", {31'h0, v[25]}, 32'd1);
      wr(1'b0, 32'h0300_0099);
      wr(1'b1, 32'h0000_0011);
      wait_idle("R5");
      rd(1'b0, v); check("R5 R11 control after write", v, 32'h0C00_0020);
      check("R6 byte written", 32'(mem[8'h20]), 32'h77);
      check("R11 busy request dropped", 32'(mem[8'h99]), 32'(8'h99 ^ 8'h5A));
      rd(1'b1, v); check("R11 data write dropped", v, 32'h77);

      // host read
      wr(1'b0, 32'h0300_0033);
      wait_idle("R6");
      rd(1'b1, v); check("R6 R8 read data", v, 32'h69);
      rd(1'b0, v); check("R7 control after read", v, 32'h0D00_0033);

      // two refusals, then success
      nak_left = 2; n0 = nak_cnt;
      wr(1'b0, 32'h0300_0010);
      wait_idle("R9");
      rd(1'b1, v); check("R9 read after retries", v, 32'h4A);
      rd(1'b0, v); check("R9 error clear after retry", v, 32'h0D00_0010);
      check("R9 refused attempts", nak_cnt - n0, 2);

      // three refusals: error
      nak_left = 3; n0 = nak_cnt;
      wr(1'b1, 32'h0000_00EE);
      wr(1'b0, 32'h0200_0040);
      wait_idle("R1");
      rd(1'b0, v); check("R1 R5 error set start clear", v, 32'h1C00_0040);
      check("R1 attempts before error", nak_cnt - n0, 3);
      check("R1 byte not written", 32'(mem[8'h40]), 32'(8'h40 ^ 8'h5A));

      wr(1'b0, 32'h0000_0040);
      rd(1'b0, v); check("R1 R2 zero write keeps flags", v, 32'h1C00_0040);
      wr(1'b0, 32'h1000_0040);
      rd(1'b0, v); check("R1 one write clears error", v, 32'h0C00_0040);

      // wrong second signature byte
      mem[1] = 8'h3D;
      do_reset();
      wait_idle("R4");
      rd(1'b0, v); check("R4 bad signature", v, 32'h0800_0000);

      // no device at all
      present = 1'b0; n0 = nak_cnt;
      do_reset();
      wait_idle("R2");
      rd(1'b0, v); check("R1 R2 absent device flags", v, 32'h1800_0000);
      check("R9 absent attempts", nak_cnt - n0, 3);
      check("R10 lines free at end", {30'h0, scl_drive_low, sda_drive_low}, 32'h0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule